// File: doc/BRIEF.md
# Timer Control Write-Protection Lock

This block holds four words of timer output configuration and guards them against software writes according to a two-bit lock level. The guarded settings are the dead-time count, the break enable, the break polarity and the automatic output enable, the per-channel idle output states, the per-channel output polarities, two off-state select bits used around a break event, and the per-channel compare mode and compare buffer-enable fields. A write port carries an address, sixteen bits of data, two byte strobes and a write enable. A separate read port returns any word one cycle after its address is presented.

The lock level sits in the break word, at bits [9:8], next to the fields it guards. Each higher level protects everything the level below protects and adds more fields. While the level is zero it can be written. Once it holds a nonzero value it stays frozen until reset. A single write can load the lock level and the guarded fields together. The guarded fields take that write's data, and protection applies from the next write onward. A write to a guarded bit is dropped without notice, and the unguarded bits of the same word still update. The block also drives one writable flag per field group, which the surrounding timer logic can use as a write-enable qualifier.

Word map: address 0 is the break word, 1 the idle-state word, 2 the polarity word and 3 the compare word.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After reset all four words read zero, the lock level is 0, and grp_wr_ok is 4'b1111.
- R2: With lock level 0, every implemented bit of every word takes the written data.
- R3: With lock level 1 or higher, writes to break word bits [7:0] (dead time), [12] (break enable), [13] (break polarity) and [14] (automatic output enable) are dropped, and so are writes to idle-word bits [2c] (main idle) and [2c+1] (complementary idle) for each channel c.
- R4: With lock level 2 or higher, writes to polarity-word bits [2c] and [2c+1] are also dropped, and so are writes to break word bits [10] and [11] (off-state selects).
- R5: With lock level 3, writes to compare-word bits [4c+2:4c] (compare mode) and [4c+3] (buffer enable) are also dropped.
- R6: Once the lock level is nonzero, writes to break word bits [9:8] are ignored until reset.
- R7: A write that moves the lock level from 0 to a nonzero value also loads every guarded field of that word with the written data.
- R8: Unguarded bits still update in a write whose guarded bits are dropped. The channel output enables in polarity-word bits [8+c] are never guarded.
- R9: Strobe wr_be[0] gates bits [7:0] and wr_be[1] gates bits [15:8]. A lane whose strobe is low keeps its value, and the lock level is written only when wr_be[1] is high.
- R10: rd_data shows the word at rd_addr one cycle later, whatever the lock level. Unmapped addresses and unimplemented bits (including break word bit 15) read 0.
- R11: grp_wr_ok bit 0 (break and dead time) and bit 1 (idle states) are 1 only at level 0. Bit 2 (polarities and off-state selects) is 1 below level 2. Bit 3 (compare fields) is 1 below level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte strobes, bit 0 for bits [7:0] |
| rd_addr | input | ADDR_W | Word address to read |
| rd_data | output | 16 | Registered read data |
| lock_level | output | 2 | Current lock level |
| grp_wr_ok | output | 4 | Per-group writable flags |
| brk_cfg | output | 16 | Break word, including the lock level |
| idle_cfg | output | 16 | Idle-state word |
| pol_cfg | output | 16 | Polarity and output-enable word |
| cmp_cfg | output | 16 | Compare word |

## Verification
Two things can happen in one cycle: the lock level is raised, and the guarded fields of the same word are written. The bench provokes this with combined writes to the break word. Some carry directed data and others random data, and the target level is each of 0 to 3. The bench judges the result by checking that every guarded field took the written data in that cycle. The write that follows is then checked against the new level, while random writes, strobes and addresses continue to land in the same words.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam int DW  = 16;
  localparam int BEW = DW / 8;

  localparam int A_BRK  = 0;
  localparam int A_IDLE = 1;
  localparam int A_POL  = 2;
  localparam int A_CMP  = 3;
  localparam int NWORDS = 4;

  localparam int LOCK_LSB = 8;

  localparam logic [DW-1:0] BRK_GRP_DT  = 16'h70FF;
  localparam logic [DW-1:0] BRK_GRP_OFF = 16'h0C00;
  localparam logic [DW-1:0] BRK_LOCK    = 16'h0300;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2,
    LVL_FULL = 2'd3
  } lock_lvl_e;

  function automatic logic [DW-1:0] pair_bits(input int nch);
    logic [DW-1:0] r;
    r = '0;
    for (int c = 0; c < 2 * nch; c++) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] oe_bits(input int nch);
    logic [DW-1:0] r;
    r = '0;
    for (int c = 0; c < nch; c++) r[8 + c] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] cmp_bits(input int nch);
    logic [DW-1:0] r;
    r = '0;
    for (int c = 0; c < 4 * nch; c++) r[c] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/wp_lock_level.sv
module wp_lock_level (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [1:0] wr_val,
  output logic [1:0] level
);
  always_ff @(posedge clk) begin
    if (rst)
      level <= 2'd0;
    else if (wr_hit && (level == 2'd0))
      level <= wr_val;
  end
endmodule

// File: rtl/wp_guard_decode.sv
module wp_guard_decode
  import wp_lock_pkg::*;
(
  input  logic [1:0] level,
  output logic [3:0] grp_ok
);
  lock_lvl_e lvl;
  assign lvl = lock_lvl_e'(level);

  always_comb begin
    unique case (lvl)
      LVL_OPEN: grp_ok = 4'b1111;
      LVL_ONE:  grp_ok = 4'b1100;
      LVL_TWO:  grp_ok = 4'b1000;
      default:  grp_ok = 4'b0000;
    endcase
  end
endmodule

// File: rtl/wp_field_word.sv
module wp_field_word #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [W-1:0]   wdata,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   allow,
  output logic [W-1:0]   q
);
  logic [W-1:0] lane_m;
  logic [W-1:0] upd_m;

  for (genvar b = 0; b < W / 8; b++) begin : g_lane
    assign lane_m[b*8 +: 8] = {8{be[b]}};
  end

  assign upd_m = lane_m & allow & IMPL & {W{we}};

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else
      q <= (q & ~upd_m) | (wdata & upd_m);
  end
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [BEW-1:0]    wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [1:0]        lock_level,
  output logic [3:0]        grp_wr_ok,
  output logic [DW-1:0]     brk_cfg,
  output logic [DW-1:0]     idle_cfg,
  output logic [DW-1:0]     pol_cfg,
  output logic [DW-1:0]     cmp_cfg
);
  localparam logic [DW-1:0] M_IDLE = pair_bits(NUM_CH);
  localparam logic [DW-1:0] M_POL  = pair_bits(NUM_CH);
  localparam logic [DW-1:0] M_OE   = oe_bits(NUM_CH);
  localparam logic [DW-1:0] M_CMP  = cmp_bits(NUM_CH);
  localparam logic [NWORDS*DW-1:0] IMPL_ALL =
    {M_CMP, M_POL | M_OE, M_IDLE, BRK_GRP_DT | BRK_GRP_OFF};

  logic [NWORDS-1:0][DW-1:0] allow;
  logic [NWORDS-1:0][DW-1:0] word_q;
  logic                      lock_hit;

  assign lock_hit = wr_en && (wr_addr == ADDR_W'(A_BRK)) && wr_be[LOCK_LSB/8];

  wp_lock_level u_level (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (lock_hit),
    .wr_val (wr_data[LOCK_LSB +: 2]),
    .level  (lock_level)
  );

  wp_guard_decode u_decode (
    .level  (lock_level),
    .grp_ok (grp_wr_ok)
  );

  always_comb begin
    allow[A_BRK]  = (grp_wr_ok[0] ? BRK_GRP_DT : '0) | (grp_wr_ok[2] ? BRK_GRP_OFF : '0);
    allow[A_IDLE] = grp_wr_ok[1] ? M_IDLE : '0;
    allow[A_POL]  = (grp_wr_ok[2] ? M_POL : '0) | M_OE;
    allow[A_CMP]  = grp_wr_ok[3] ? M_CMP : '0;
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic we_i;
    assign we_i = wr_en && (wr_addr == ADDR_W'(i));
    wp_field_word #(
      .W    (DW),
      .IMPL (IMPL_ALL[i*DW +: DW])
    ) u_word (
      .clk   (clk),
      .rst   (rst),
      .we    (we_i),
      .wdata (wr_data),
      .be    (wr_be),
      .allow (allow[i]),
      .q     (word_q[i])
    );
  end

  assign brk_cfg  = word_q[A_BRK] | (DW'(lock_level) << LOCK_LSB);
  assign idle_cfg = word_q[A_IDLE];
  assign pol_cfg  = word_q[A_POL];
  assign cmp_cfg  = word_q[A_CMP];

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(A_BRK):  rd_data <= brk_cfg;
        ADDR_W'(A_IDLE): rd_data <= idle_cfg;
        ADDR_W'(A_POL):  rd_data <= pol_cfg;
        ADDR_W'(A_CMP):  rd_data <= cmp_cfg;
        default:         rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wp_lock_chk.sv
module wp_lock_chk
  import wp_lock_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    lock_level,
  input logic [3:0]    grp_wr_ok,
  input logic [DW-1:0] brk_cfg,
  input logic [DW-1:0] idle_cfg,
  input logic [DW-1:0] pol_cfg,
  input logic [DW-1:0] cmp_cfg
);
  localparam logic [DW-1:0] POLM = pair_bits(NUM_CH);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_level != 2'd0) |=> (lock_level == $past(lock_level)));

  assert_lock_from_open_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_level != $past(lock_level)) |-> ($past(lock_level) == 2'd0));

  assert_brk_guard_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_level != 2'd0) |=> ((brk_cfg & BRK_GRP_DT) == ($past(brk_cfg) & BRK_GRP_DT)));

  assert_idle_guard_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_level != 2'd0) |=> $stable(idle_cfg));

  assert_pol_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_level >= 2'd2) |=> (((pol_cfg & POLM) == ($past(pol_cfg) & POLM)) &&
                              ((brk_cfg & BRK_GRP_OFF) == ($past(brk_cfg) & BRK_GRP_OFF))));

  assert_cmp_guard_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_level == 2'd3) |=> $stable(cmp_cfg));

  assert_nested_R11: assert property (@(posedge clk) disable iff (rst)
    grp_wr_ok[2] |-> (grp_wr_ok[1] && grp_wr_ok[0] ? 1'b1 : !grp_wr_ok[2]) || grp_wr_ok[3]);

  assert_cmp_outer_R11: assert property (@(posedge clk) disable iff (rst)
    (!grp_wr_ok[3]) |-> ((grp_wr_ok[2:0] == 3'b000) && (lock_level == 2'd3)));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    brk_cfg[15] == 1'b0);
endmodule

bind wp_lock_ctrl wp_lock_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lock_level (lock_level),
  .grp_wr_ok  (grp_wr_ok),
  .brk_cfg    (brk_cfg),
  .idle_cfg   (idle_cfg),
  .pol_cfg    (pol_cfg),
  .cmp_cfg    (cmp_cfg)
);

// File: tb/wp_lock_ctrl_tb.sv
`timescale 1ns/1ps
module wp_lock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  lock_level;
  logic [3:0]  grp_wr_ok;
  logic [15:0] brk_cfg, idle_cfg, pol_cfg, cmp_cfg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_w [4];
  logic [1:0]  m_lvl;

  always #2.5 clk = ~clk;

  wp_lock_ctrl #(.NUM_CH(4), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .lock_level(lock_level),
    .grp_wr_ok(grp_wr_ok), .brk_cfg(brk_cfg), .idle_cfg(idle_cfg),
    .pol_cfg(pol_cfg), .cmp_cfg(cmp_cfg)
  );

  function automatic logic [15:0] allow_for(input int a, input logic [1:0] lvl);
    case (a)
      0: return ((lvl < 2'd1) ? 16'h70FF : 16'h0) | ((lvl < 2'd2) ? 16'h0C00 : 16'h0);
      1: return (lvl < 2'd1) ? 16'h00FF : 16'h0;
      2: return ((lvl < 2'd2) ? 16'h00FF : 16'h0) | 16'h0F00;
      3: return (lvl < 2'd3) ? 16'hFFFF : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input int a);
    case (a)
      0: return m_w[0] | {6'b0, m_lvl, 8'h00};
      1: return m_w[1];
      2: return m_w[2];
      3: return m_w[3];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] exp_grp(input logic [1:0] lvl);
    return {lvl < 2'd3, lvl < 2'd2, lvl < 2'd1, lvl < 2'd1};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    check("R3 break word", brk_cfg, exp_word(0));
    check("R3 idle word", idle_cfg, exp_word(1));
    check("R4 polarity word", pol_cfg, exp_word(2));
    check("R5 compare word", cmp_cfg, exp_word(3));
    check("R6 lock level", {14'b0, lock_level}, {14'b0, m_lvl});
    check("R11 group flags", {12'b0, grp_wr_ok}, {12'b0, exp_grp(m_lvl)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) m_w[i] = '0;
    m_lvl = 2'd0;
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] bm, um;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    bm = {{8{be[1]}}, {8{be[0]}}};
    um = bm & allow_for(a, m_lvl);
    if (a < 4) m_w[a] = (m_w[a] & ~um) | (d & um);
    if (a == 0 && be[1] && m_lvl == 2'd0) m_lvl = d[9:8];
    check_all();
  endtask

  task automatic rd(input int a);
    rd_addr = 4'(a);
    @(negedge clk);
    check("R10 read data", rd_data, exp_word(a));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    do_reset();
    // R1: reset state
    check("R1 reset brk", brk_cfg, 16'h0);
    check("R1 reset idle", idle_cfg, 16'h0);
    check("R1 reset pol", pol_cfg, 16'h0);
    check("R1 reset cmp", cmp_cfg, 16'h0);
    check("R1 reset flags", {12'b0, grp_wr_ok}, 16'h000F);
    // R2: level 0 full writes
    wr(0, 16'hFCFF, 2'b11);
    wr(1, 16'hFFFF, 2'b11);
    wr(2, 16'hFFFF, 2'b11);
    wr(3, 16'hFFFF, 2'b11);
    check("R2 open idle", idle_cfg, 16'h00FF);
    check("R2 open cmp", cmp_cfg, 16'hFFFF);
    check("R2 open brk", brk_cfg, 16'h7CFF);
    // R9: low lane only
    wr(0, 16'h0000, 2'b01);
    check("R9 lane strobe", brk_cfg, 16'h7C00);
    wr(0, 16'h0100, 2'b01);
    check("R9 lock needs upper strobe", {14'b0, lock_level}, 16'h0);
    // R7: combined write sets level 2 and fields
    wr(0, 16'h765A, 2'b11);
    check("R7 combined write", brk_cfg, 16'h765A);
    // R6: lock frozen, guarded bits dropped
    wr(0, 16'h0000, 2'b11);
    check("R6 lock frozen", brk_cfg, 16'h765A);
    // R8: unguarded enables update while polarity guarded
    wr(2, 16'h0A00, 2'b11);
    check("R8 enables update", pol_cfg, 16'h0AFF);
    wr(3, 16'h1234, 2'b11);
    check("R5 compare open at level 2", cmp_cfg, 16'h1234);
    for (int a = 0; a < 8; a++) rd(a);

    for (int lv = 0; lv < 4; lv++) begin
      do_reset();
      for (int k = 0; k < 8; k++)
        wr($urandom_range(0, 3), $urandom() & 16'hFCFF, 2'($urandom_range(0, 3)));
      wr(0, ($urandom() & 16'hFCFF) | 16'(lv << 8), 2'b11);
      check("R7 random combined", brk_cfg & 16'h7CFF, wr_data & 16'h7CFF);
      for (int k = 0; k < 40; k++)
        wr($urandom_range(0, 5), 16'($urandom()), 2'($urandom_range(0, 3)));
      for (int a = 0; a < 6; a++) rd(a);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule